// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer controlled through one 16-bit register on a simple synchronous write port, with the register contents visible at all times on a read bus. Software picks one of four timeout periods and enables the timer. It must then restart the count with a write-only strobe bit before the period runs out. If the period elapses first, the block raises a processor reset request for a fixed number of cycles. It can also pulse an interrupt.

A lock bit makes the configuration permanent until the next reset. Once it is set, every write is ignored and the timer keeps running whatever the enable bit says. An expiry clears the configuration fields. A sticky flag records the expiry, survives the reset that the watchdog itself requests, and is cleared only by the external hardware reset. Time is counted in ticks from a prescaler on the system clock. The tick length and the four periods are parameters given in microseconds.

Top module: `lockWatchdog`

## Requirements
- R1: After the external hardware reset (hwRstN low), rdData reads 0x0000 and cpuRstReq and wdtIrq are low.
- R2: A write while unlocked and not in reset hold stores wrData[4:3] as the period code, wrData[2] as lock and wrData[1] as enable. These read back in the same bit positions. Bit 0, bits 15:6 and the flag at bit 5 cannot be set by a write, and bit 0 always reads 0.
- R3: Period codes 0, 1, 2 and 3 select 14, 55, 220 and 660 ticks (1.4, 5.5, 22 and 66 ms with the default 100 us tick). Expiry occurs exactly code-ticks × TICK_CYCLES clock edges after the write edge that starts or restarts the count.
- R4: A write with bit 0 set restarts the count from zero. A restart at the same edge where expiry would occur prevents that expiry.
- R5: On expiry, cpuRstReq goes high at the next edge and stays high for exactly RST_CYCLES cycles.
- R6: With IRQ_EN set, wdtIrq is high for exactly one cycle, in the same cycle that cpuRstReq rises.
- R7: While lock reads 1, every write is ignored, including the restart strobe and attempts to clear enable. The timer runs even if the enable bit is 0.
- R8: Expiry sets the flag at bit 5 and clears enable, lock and the period code. The register then reads 0x0020. The flag stays set until hwRstN is asserted.
- R9: Writing enable 0 while unlocked stops the count and zeroes it. A later enable counts a full period from that write.
- R10: Writes are ignored while cpuRstReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hwRstN | input | 1 | External hardware reset, asynchronous, active low |
| wrEn | input | 1 | Register write strobe, sampled at the rising edge |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Current register contents |
| cpuRstReq | output | 1 | Processor reset request, held RST_CYCLES cycles after expiry |
| wdtIrq | output | 1 | One-cycle interrupt at expiry |

## Verification
A register write takes effect at the edge that samples it, so readback is checked one cycle later. Expiry is registered, so cpuRstReq, wdtIrq and the flag change exactly N×TICK_CYCLES edges after the write edge that began the count. The bench samples on the falling edge one cycle before that point, expecting no reset, and again right at it. The hold length is checked by sampling the last high cycle and the first low cycle. The interrupt is checked by sampling it high at expiry and low one cycle later. Random restart gaps are kept at least one edge short of the period, so every random sequence has a known outcome.

// File: rtl/lockWatchdogPkg.sv
package lockWatchdogPkg;

  // Strobes and levels from the register control to the counting datapath.
  typedef struct packed {
    logic       run;      // count advances on ticks
    logic       restart;  // zero the count and the prescaler this edge
    logic [1:0] period;   // active period code
  } ctlStrobes_t;

  // Field positions inside the 16-bit register.
  localparam int BIT_STROBE = 0;
  localparam int BIT_EN     = 1;
  localparam int BIT_LOCK   = 2;
  localparam int BIT_PER_LO = 3;
  localparam int BIT_FLAG   = 5;

endpackage

// File: rtl/lockWatchdogCtrl.sv
module lockWatchdogCtrl
  import lockWatchdogPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        expire,
  input  logic        holdActive,
  output ctlStrobes_t ctl,
  output logic [15:0] rdData
);

  logic       enQ;
  logic       lockQ;
  logic       flagQ;
  logic [1:0] perQ;
  logic       wrOk;

  // Writes land only when unlocked and not in a reset hold.
  assign wrOk = wrEn && !lockQ && !holdActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      lockQ <= 1'b0;
      flagQ <= 1'b0;
      perQ  <= 2'd0;
    end else if (expire) begin
      enQ   <= 1'b0;
      lockQ <= 1'b0;
      perQ  <= 2'd0;
      flagQ <= 1'b1;
    end else if (wrOk) begin
      enQ   <= wrData[BIT_EN];
      lockQ <= wrData[BIT_LOCK];
      perQ  <= wrData[BIT_PER_LO +: 2];
    end
  end

  always_comb begin
    ctl.run     = enQ | lockQ;
    ctl.restart = wrOk && wrData[BIT_STROBE];
    ctl.period  = perQ;
  end

  always_comb begin
    rdData = 16'd0;
    rdData[BIT_EN]          = enQ;
    rdData[BIT_LOCK]        = lockQ;
    rdData[BIT_PER_LO +: 2] = perQ;
    rdData[BIT_FLAG]        = flagQ;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flagQ |=> flagQ); // R8
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !expire) |=> (lockQ && $stable(perQ) && $stable(enQ))); // R7
  AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (flagQ && !enQ && !lockQ && perQ == 2'd0)); // R8
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && !expire) |=> $stable(rdData)); // R10

endmodule

// File: rtl/lockWatchdogDp.sv
module lockWatchdogDp
  import lockWatchdogPkg::*;
#(
  parameter int unsigned TICK_CYCLES = 5000,
  parameter int unsigned LIM0        = 14,
  parameter int unsigned LIM1        = 55,
  parameter int unsigned LIM2        = 220,
  parameter int unsigned LIM3        = 660,
  parameter int unsigned RST_CYCLES  = 16,
  parameter bit          IRQ_EN      = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output logic        expire,
  output logic        cpuRstReq,
  output logic        wdtIrq
);

  localparam int unsigned PRE_W  = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam int unsigned MAX_01 = (LIM0 > LIM1) ? LIM0 : LIM1;
  localparam int unsigned MAX_23 = (LIM2 > LIM3) ? LIM2 : LIM3;
  localparam int unsigned LIM_MAX = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
  localparam int unsigned CNT_W  = $clog2(LIM_MAX + 1);
  localparam int unsigned RST_W  = $clog2(RST_CYCLES + 1);

  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limit;
  logic [RST_W-1:0] holdQ;
  logic             tick;

  always_comb begin
    case (ctl.period)
      2'd0:    limit = CNT_W'(LIM0);
      2'd1:    limit = CNT_W'(LIM1);
      2'd2:    limit = CNT_W'(LIM2);
      default: limit = CNT_W'(LIM3);
    endcase
  end

  assign tick   = (preQ == PRE_W'(TICK_CYCLES - 1));
  assign expire = ctl.run && !ctl.restart && tick && (cntQ >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (ctl.restart || !ctl.run || expire) begin
      preQ <= '0;
      cntQ <= '0;
    end else if (tick) begin
      preQ <= '0;
      cntQ <= cntQ + CNT_W'(1);
    end else begin
      preQ <= preQ + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdQ <= '0;
    else if (expire)          holdQ <= RST_W'(RST_CYCLES);
    else if (holdQ != '0)     holdQ <= holdQ - RST_W'(1);
  end

  assign cpuRstReq = (holdQ != '0);

  generate
    if (IRQ_EN) begin : g_irq
      logic irqQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqQ <= 1'b0;
        else       irqQ <= expire;
      end
      assign wdtIrq = irqQ;
      AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
        irqQ |=> !irqQ); // R6
    end else begin : g_noIrq
      assign wdtIrq = 1'b0;
    end
  endgenerate

  AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> cpuRstReq); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (cntQ == '0)); // R9
  AST_RESTART_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.restart && !cpuRstReq) |=> !cpuRstReq); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(LIM_MAX)); // R3

endmodule

// File: rtl/lockWatchdog.sv
module lockWatchdog
  import lockWatchdogPkg::*;
#(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned TICK_US    = 100,
  parameter int unsigned PER0_US    = 1400,
  parameter int unsigned PER1_US    = 5500,
  parameter int unsigned PER2_US    = 22000,
  parameter int unsigned PER3_US    = 66000,
  parameter int unsigned RST_CYCLES = 16,
  parameter bit          IRQ_EN     = 1'b1
) (
  input  logic        clk,
  input  logic        hwRstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        cpuRstReq,
  output logic        wdtIrq
);

  localparam int unsigned TICK_CYCLES = (CLK_KHZ * TICK_US) / 1000;
  localparam int unsigned LIM0 = PER0_US / TICK_US;
  localparam int unsigned LIM1 = PER1_US / TICK_US;
  localparam int unsigned LIM2 = PER2_US / TICK_US;
  localparam int unsigned LIM3 = PER3_US / TICK_US;

  ctlStrobes_t ctl;
  logic        expire;

  lockWatchdogCtrl u_ctrl (
    .clk        (clk),
    .rstN       (hwRstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .expire     (expire),
    .holdActive (cpuRstReq),
    .ctl        (ctl),
    .rdData     (rdData)
  );

  lockWatchdogDp #(
    .TICK_CYCLES (TICK_CYCLES),
    .LIM0        (LIM0),
    .LIM1        (LIM1),
    .LIM2        (LIM2),
    .LIM3        (LIM3),
    .RST_CYCLES  (RST_CYCLES),
    .IRQ_EN      (IRQ_EN)
  ) u_dp (
    .clk       (clk),
    .rstN      (hwRstN),
    .ctl       (ctl),
    .expire    (expire),
    .cpuRstReq (cpuRstReq),
    .wdtIrq    (wdtIrq)
  );

endmodule

// File: tb/lockWatchdog_tb.sv
module lockWatchdog_tb;

  localparam int TB_TICK = 4;   // 40 kHz * 100 us / 1000
  localparam int TB_HOLD = 6;

  logic        clk = 1'b0;
  logic        hwRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        cpuRstReq;
  logic        wdtIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lockWatchdog #(
    .CLK_KHZ    (40),
    .TICK_US    (100),
    .RST_CYCLES (TB_HOLD),
    .IRQ_EN     (1'b1)
  ) u_dut (
    .clk       (clk),
    .hwRstN    (hwRstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .cpuRstReq (cpuRstReq),
    .wdtIrq    (wdtIrq)
  );

  function automatic int periodCycles(input int sel);
    int t;
    case (sel)
      0: t = 14;
      1: t = 55;
      2: t = 220;
      default: t = 660;
    endcase
    return t * TB_TICK;
  endfunction

  function automatic logic [15:0] cfgWord(input int sel, input bit lk, input bit en, input bit kick);
    return {11'd0, 2'(sel), lk, en, kick};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic writeReg(input logic [15:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = 16'd0;
  endtask

  task automatic hwReset();
    hwRstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hwRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // After a write edge that started the count, check the expiry edge exactly.
  task automatic expectExpiry(input string req, input int n);
    waitCyc(n - 1);
    chk(req, {14'd0, cpuRstReq, wdtIrq}, 16'd0);
    waitCyc(1);
    chk(req, {14'd0, cpuRstReq, wdtIrq}, 16'd3);
    chk("R8", rdData, 16'h0020);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    int gap;
    int sel;
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", rdData, 16'h0000);
    chk("R1", {14'd0, cpuRstReq, wdtIrq}, 16'd0);
    hwRstN = 1'b1;
    @(negedge clk);
    chk("R1", rdData, 16'h0000);

    // R2: layout, reserved bits, strobe and flag not writable
    writeReg(16'hFFE0 | cfgWord(2, 0, 0, 1));
    chk("R2", rdData, 16'h0010);
    writeReg(cfgWord(1, 0, 1, 0) | 16'h0020);
    chk("R2", rdData, 16'h000A);
    writeReg(16'h0000);

    // R3: every period code, exact expiry edge
    for (int s = 0; s < 4; s++) begin
      hwReset();
      writeReg(cfgWord(s, 0, 1, 0));
      expectExpiry("R3", periodCycles(s));
    end

    // R5 and R6: hold length and interrupt pulse
    waitCyc(1);
    chk("R6", {15'd0, wdtIrq}, 16'd0);
    waitCyc(TB_HOLD - 2);
    chk("R5", {15'd0, cpuRstReq}, 16'd1);
    waitCyc(1);
    chk("R5", {15'd0, cpuRstReq}, 16'd0);
    // R8: flag survives watchdog reset, cleared by hardware reset
    chk("R8", rdData, 16'h0020);
    hwReset();
    chk("R8", rdData, 16'h0000);

    // R10: writes ignored while reset request held
    writeReg(cfgWord(0, 0, 1, 0));
    expectExpiry("R10", periodCycles(0));
    writeReg(cfgWord(3, 0, 1, 0));
    chk("R10", rdData, 16'h0020);
    waitCyc(TB_HOLD + 1);
    chk("R10", {15'd0, cpuRstReq}, 16'd0);

    // R4: restart exactly at the would-be expiry edge
    hwReset();
    n = periodCycles(0);
    writeReg(cfgWord(0, 0, 1, 0));
    waitCyc(n - 1);
    writeReg(cfgWord(0, 0, 1, 1));
    chk("R4", {15'd0, cpuRstReq}, 16'd0);
    chk("R4", rdData, 16'h0002);
    expectExpiry("R4", n - 1 + 1);

    // R9: disable stops and zeroes the count
    hwReset();
    writeReg(cfgWord(0, 0, 1, 0));
    waitCyc(30);
    writeReg(cfgWord(0, 0, 0, 0));
    waitCyc(200);
    chk("R9", {15'd0, cpuRstReq}, 16'd0);
    writeReg(cfgWord(0, 0, 1, 0));
    expectExpiry("R9", periodCycles(0));

    // R7: locked with enable 0 still runs; writes and strobes ignored
    hwReset();
    writeReg(cfgWord(1, 1, 0, 0));
    chk("R7", rdData, 16'h000C);
    waitCyc(20);
    writeReg(cfgWord(0, 0, 0, 1));
    chk("R7", rdData, 16'h000C);
    expectExpiry("R7", periodCycles(1) - 21);

    // Random restart sequences (R4, R3)
    for (int it = 0; it < 6; it++) begin
      hwReset();
      sel = int'($urandom % 2);
      n = periodCycles(sel);
      writeReg(cfgWord(sel, 0, 1, 0));
      for (int k = 0; k < 4; k++) begin
        gap = int'($urandom % (n - 2)) + 1;
        waitCyc(gap);
        chk("R4", {15'd0, cpuRstReq}, 16'd0);
        writeReg(cfgWord(sel, 0, 1, 1));
      end
      expectExpiry("R3", n);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule